// File: doc/BRIEF.md
# Reservation Station Issue Queue

This block sits in front of a single ALU and holds up to four dispatched operations. Each slot keeps its operation code, two source operands (a producer tag, a value and a ready flag for each) and an age rank. An operand that the register file already holds is written ready at dispatch. An operand that is still being computed waits for a result-bus broadcast that carries its producer's tag. When the tag matches, the slot takes the broadcast value.

A slot becomes a candidate for issue once both of its operands are ready. It does not wait for older slots, so a younger independent operation can pass an older stalled one. When several slots are candidates, the one with the lowest age rank goes to the ALU. At most one operation issues per clock. No operation issues while the ALU reports busy. A slot is released in the cycle it issues and can take a new dispatch from the next cycle on. Dispatch is refused while every slot is occupied.

Top module: `rs_issue_queue`

## Requirements
- R1: After reset, `iss_valid_o` is 0 and `disp_ready_o` is 1.
- R2: Operands dispatched with their ready flag set are stored with the given values. With the ALU free, the operation issues in the cycle after dispatch, and `iss_op_o`, `iss_val1_o` and `iss_val2_o` carry the dispatched opcode and values.
- R3: A waiting operand whose tag equals `cdb_tag_i` while `cdb_valid_i` is 1 takes `cdb_data_i` at that clock edge. Once both operands are ready, the slot can issue in the next cycle.
- R4: A broadcast whose tag differs from a waiting operand's tag leaves that operand waiting, and the slot does not issue.
- R5: A dispatched operand that is not ready but whose tag equals the broadcast tag in the dispatch cycle takes the broadcast value directly, so the wake-up is not lost.
- R6: A slot with both operands ready issues even while an older slot is still waiting for an operand.
- R7: Among ready slots, the one dispatched earliest issues first, whatever slot index it occupies.
- R8: At most one slot issues per cycle. While `alu_busy_i` is 1, `iss_valid_o` is 0 and no slot is released.
- R9: With all four slots occupied, `disp_ready_o` is 0, and a dispatch offered then is dropped and never issues.
- R10: A slot is released at the clock edge of its issue cycle. With a full queue, `disp_ready_o` stays 0 during the issue cycle and rises in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| disp_valid_i | input | 1 | Dispatch request |
| disp_ready_o | output | 1 | A free slot exists; dispatch accepted when both are 1 |
| disp_op_i | input | OP_W | Operation code |
| disp_src1_tag_i | input | TAG_W | Producer tag of the first operand |
| disp_src1_val_i | input | DATA_W | Value of the first operand if ready |
| disp_src1_rdy_i | input | 1 | First operand ready at dispatch |
| disp_src2_tag_i | input | TAG_W | Producer tag of the second operand |
| disp_src2_val_i | input | DATA_W | Value of the second operand if ready |
| disp_src2_rdy_i | input | 1 | Second operand ready at dispatch |
| cdb_valid_i | input | 1 | Result-bus broadcast valid |
| cdb_tag_i | input | TAG_W | Tag of the broadcast result |
| cdb_data_i | input | DATA_W | Broadcast result value |
| alu_busy_i | input | 1 | ALU cannot accept an operation this cycle |
| iss_valid_o | output | 1 | An operation is issued this cycle |
| iss_op_o | output | OP_W | Issued operation code |
| iss_val1_o | output | DATA_W | Issued first operand |
| iss_val2_o | output | DATA_W | Issued second operand |

## Verification
Most internal faults show up at the issue port within a few cycles:
- A corrupted age rank issues the wrong slot first as soon as two ready slots compete.
- A missed wake-up leaves `iss_valid_o` low one cycle after the broadcast, when it should be high.
- A spurious wake-up issues an operation early, carrying a wrong operand value.
- A leaked or stuck valid bit shows in `disp_ready_o` when the queue is full or just draining. It also shows as an extra or missing operation when the queue is emptied.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  parameter int unsigned RSQ_ENTRIES = 4;
  parameter int unsigned RSQ_DATA_W  = 16;
  parameter int unsigned RSQ_TAG_W   = 4;
  parameter int unsigned RSQ_OP_W    = 3;
  localparam int unsigned RSQ_NUM_SRC = 2;
endpackage

// File: rtl/rsq_alloc.sv
module rsq_alloc #(
  parameter int unsigned N = rsq_pkg::RSQ_ENTRIES
) (
  input  logic [N-1:0] valid_i,
  output logic         free_o,
  output logic [N-1:0] slot_o
);
  // lowest free slot, one-hot
  always_comb begin
    slot_o = '0;
    free_o = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!valid_i[i] && !free_o) begin
        slot_o[i] = 1'b1;
        free_o    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rsq_select.sv
module rsq_select #(
  parameter int unsigned N     = rsq_pkg::RSQ_ENTRIES,
  parameter int unsigned AGE_W = $clog2(N),
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]            ready_i,
  input  logic [N-1:0][AGE_W-1:0] age_i,
  input  logic                    en_i,
  output logic [N-1:0]            grant_o,
  output logic [IDX_W-1:0]        idx_o,
  output logic                    any_o
);
  logic [AGE_W-1:0] best;

  // smallest age rank wins; ranks are unique among valid slots
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    best  = '0;
    for (int i = 0; i < N; i++) begin
      if (en_i && ready_i[i] && (!any_o || age_i[i] < best)) begin
        any_o = 1'b1;
        best  = age_i[i];
        idx_o = IDX_W'(i);
      end
    end
    grant_o = '0;
    grant_o[idx_o] = any_o;
  end
endmodule

// File: rtl/rsq_entry.sv
module rsq_entry #(
  parameter int unsigned DATA_W = rsq_pkg::RSQ_DATA_W,
  parameter int unsigned TAG_W  = rsq_pkg::RSQ_TAG_W,
  parameter int unsigned OP_W   = rsq_pkg::RSQ_OP_W,
  parameter int unsigned AGE_W  = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   alloc_i,
  input  logic [OP_W-1:0]        op_i,
  input  logic [1:0][TAG_W-1:0]  tag_i,
  input  logic [1:0][DATA_W-1:0] val_i,
  input  logic [1:0]             rdy_i,
  input  logic [AGE_W-1:0]       age_new_i,
  input  logic                   age_dec_i,
  input  logic                   cdb_valid_i,
  input  logic [TAG_W-1:0]       cdb_tag_i,
  input  logic [DATA_W-1:0]      cdb_data_i,
  input  logic                   grant_i,
  output logic                   valid_o,
  output logic                   ready_o,
  output logic [OP_W-1:0]        op_o,
  output logic [DATA_W-1:0]      val1_o,
  output logic [DATA_W-1:0]      val2_o,
  output logic [AGE_W-1:0]       age_o
);
  logic                   valid_q;
  logic [OP_W-1:0]        op_q;
  logic [1:0][TAG_W-1:0]  tag_q;
  logic [1:0][DATA_W-1:0] val_q;
  logic [1:0]             rdy_q;
  logic [AGE_W-1:0]       age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      op_q    <= '0;
      tag_q   <= '0;
      val_q   <= '0;
      rdy_q   <= '0;
      age_q   <= '0;
    end else if (alloc_i) begin
      valid_q <= 1'b1;
      op_q    <= op_i;
      age_q   <= age_new_i;
      for (int k = 0; k < 2; k++) begin
        tag_q[k] <= tag_i[k];
        if (rdy_i[k]) begin
          val_q[k] <= val_i[k];
          rdy_q[k] <= 1'b1;
        end else if (cdb_valid_i && cdb_tag_i == tag_i[k]) begin
          val_q[k] <= cdb_data_i;   // same-cycle wake-up
          rdy_q[k] <= 1'b1;
        end else begin
          val_q[k] <= '0;
          rdy_q[k] <= 1'b0;
        end
      end
    end else begin
      if (grant_i) valid_q <= 1'b0;
      if (age_dec_i) age_q <= age_q - 1'b1;
      for (int k = 0; k < 2; k++) begin
        if (valid_q && !rdy_q[k] && cdb_valid_i && cdb_tag_i == tag_q[k]) begin
          val_q[k] <= cdb_data_i;
          rdy_q[k] <= 1'b1;
        end
      end
    end
  end

  assign valid_o = valid_q;
  assign ready_o = valid_q && (&rdy_q);
  assign op_o    = op_q;
  assign val1_o  = val_q[0];
  assign val2_o  = val_q[1];
  assign age_o   = age_q;

  assert_grant_ready_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_i |-> (valid_q && rdy_q == 2'b11));
  assert_clear_on_issue_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_i |=> !valid_q);
  assert_alloc_free_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> !valid_q);
  assert_wakeup_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !alloc_i && !rdy_q[0] && cdb_valid_i && cdb_tag_i == tag_q[0])
      |=> (rdy_q[0] && val_q[0] == $past(cdb_data_i)));
endmodule

// File: rtl/rs_issue_queue.sv
module rs_issue_queue #(
  parameter int unsigned NUM_ENTRIES = rsq_pkg::RSQ_ENTRIES,
  parameter int unsigned DATA_W      = rsq_pkg::RSQ_DATA_W,
  parameter int unsigned TAG_W       = rsq_pkg::RSQ_TAG_W,
  parameter int unsigned OP_W        = rsq_pkg::RSQ_OP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              disp_valid_i,
  output logic              disp_ready_o,
  input  logic [OP_W-1:0]   disp_op_i,
  input  logic [TAG_W-1:0]  disp_src1_tag_i,
  input  logic [DATA_W-1:0] disp_src1_val_i,
  input  logic              disp_src1_rdy_i,
  input  logic [TAG_W-1:0]  disp_src2_tag_i,
  input  logic [DATA_W-1:0] disp_src2_val_i,
  input  logic              disp_src2_rdy_i,
  input  logic              cdb_valid_i,
  input  logic [TAG_W-1:0]  cdb_tag_i,
  input  logic [DATA_W-1:0] cdb_data_i,
  input  logic              alu_busy_i,
  output logic              iss_valid_o,
  output logic [OP_W-1:0]   iss_op_o,
  output logic [DATA_W-1:0] iss_val1_o,
  output logic [DATA_W-1:0] iss_val2_o
);
  localparam int unsigned AGE_W = $clog2(NUM_ENTRIES);
  localparam int unsigned IDX_W = $clog2(NUM_ENTRIES);

  logic [NUM_ENTRIES-1:0]              valid, ready, grant, alloc, slot, age_dec;
  logic [NUM_ENTRIES-1:0][OP_W-1:0]    ent_op;
  logic [NUM_ENTRIES-1:0][DATA_W-1:0]  ent_v1, ent_v2;
  logic [NUM_ENTRIES-1:0][AGE_W-1:0]   ent_age;
  logic [IDX_W-1:0] gnt_idx;
  logic             gnt_any, free_any, disp_fire;
  logic [AGE_W-1:0] gnt_age, new_age;

  rsq_alloc #(.N(NUM_ENTRIES)) u_alloc (
    .valid_i (valid),
    .free_o  (free_any),
    .slot_o  (slot)
  );

  rsq_select #(.N(NUM_ENTRIES), .AGE_W(AGE_W), .IDX_W(IDX_W)) u_select (
    .ready_i (ready),
    .age_i   (ent_age),
    .en_i    (!alu_busy_i),
    .grant_o (grant),
    .idx_o   (gnt_idx),
    .any_o   (gnt_any)
  );

  assign disp_ready_o = free_any;
  assign disp_fire    = disp_valid_i && free_any;
  assign alloc        = disp_fire ? slot : '0;
  assign gnt_age      = ent_age[gnt_idx];
  // new slot ranks behind every slot that survives this cycle
  assign new_age      = AGE_W'($countones(valid & ~grant));

  always_comb begin
    for (int i = 0; i < NUM_ENTRIES; i++)
      age_dec[i] = valid[i] && gnt_any && (ent_age[i] > gnt_age);
  end

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
    rsq_entry #(.DATA_W(DATA_W), .TAG_W(TAG_W), .OP_W(OP_W), .AGE_W(AGE_W)) u_ent (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .alloc_i     (alloc[g]),
      .op_i        (disp_op_i),
      .tag_i       ({disp_src2_tag_i, disp_src1_tag_i}),
      .val_i       ({disp_src2_val_i, disp_src1_val_i}),
      .rdy_i       ({disp_src2_rdy_i, disp_src1_rdy_i}),
      .age_new_i   (new_age),
      .age_dec_i   (age_dec[g]),
      .cdb_valid_i (cdb_valid_i),
      .cdb_tag_i   (cdb_tag_i),
      .cdb_data_i  (cdb_data_i),
      .grant_i     (grant[g]),
      .valid_o     (valid[g]),
      .ready_o     (ready[g]),
      .op_o        (ent_op[g]),
      .val1_o      (ent_v1[g]),
      .val2_o      (ent_v2[g]),
      .age_o       (ent_age[g])
    );
  end

  assign iss_valid_o = gnt_any;
  assign iss_op_o    = ent_op[gnt_idx];
  assign iss_val1_o  = ent_v1[gnt_idx];
  assign iss_val2_o  = ent_v2[gnt_idx];

  assert_one_issue_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant));
  assert_busy_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alu_busy_i |=> (($past(valid) & ~valid) == '0));
  assert_full_refuse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !disp_ready_o |=> ($countones(valid) <= $past($countones(valid))));
  assert_issue_ready_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_valid_o |-> ((grant & ~ready) == '0));
endmodule

// File: tb/rs_issue_queue_tb_top.sv
`timescale 1ns/1ps
module rs_issue_queue_tb_top;
  localparam int DATA_W = 16;
  localparam int TAG_W  = 4;
  localparam int OP_W   = 3;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic disp_valid_i = 1'b0, disp_ready_o;
  logic [OP_W-1:0] disp_op_i = '0;
  logic [TAG_W-1:0] disp_src1_tag_i = '0, disp_src2_tag_i = '0;
  logic [DATA_W-1:0] disp_src1_val_i = '0, disp_src2_val_i = '0;
  logic disp_src1_rdy_i = 1'b0, disp_src2_rdy_i = 1'b0;
  logic cdb_valid_i = 1'b0;
  logic [TAG_W-1:0] cdb_tag_i = '0;
  logic [DATA_W-1:0] cdb_data_i = '0;
  logic alu_busy_i = 1'b0;
  logic iss_valid_o;
  logic [OP_W-1:0] iss_op_o;
  logic [DATA_W-1:0] iss_val1_o, iss_val2_o;

  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  rs_issue_queue dut_i (.*);

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic put(input int op, input int t1, input int v1, input bit r1,
                     input int t2, input int v2, input bit r2);
    disp_op_i = OP_W'(op);
    disp_src1_tag_i = TAG_W'(t1); disp_src1_val_i = DATA_W'(v1); disp_src1_rdy_i = r1;
    disp_src2_tag_i = TAG_W'(t2); disp_src2_val_i = DATA_W'(v2); disp_src2_rdy_i = r2;
    disp_valid_i = 1'b1;
    step();
    disp_valid_i = 1'b0;
  endtask

  task automatic issue_chk(input string req, input bit ev, input int op, input int v1, input int v2);
    #2;
    chk(req, "iss_valid", int'(iss_valid_o), int'(ev));
    if (ev) begin
      chk(req, "iss_op", int'(iss_op_o), op);
      chk(req, "iss_val1", int'(iss_val1_o), v1);
      chk(req, "iss_val2", int'(iss_val2_o), v2);
    end
  endtask

  task automatic t_reset();
    #2;
    chk("R1", "iss_valid", int'(iss_valid_o), 0);
    chk("R1", "disp_ready", int'(disp_ready_o), 1);
  endtask

  task automatic t_basic();
    put(1, 0, 10, 1, 0, 20, 1);
    issue_chk("R2", 1, 1, 10, 20);
    step();
    issue_chk("R2", 0, 0, 0, 0);
  endtask

  task automatic t_ooo_wakeup();
    alu_busy_i = 1'b1;
    put(2, 5, 0, 0, 0, 3, 1);
    put(3, 0, 7, 1, 0, 8, 1);
    alu_busy_i = 1'b0;
    issue_chk("R6", 1, 3, 7, 8);
    step();
    issue_chk("R6", 0, 0, 0, 0);
    cdb_valid_i = 1'b1; cdb_tag_i = 4'd9; cdb_data_i = 16'd99;
    step();
    cdb_valid_i = 1'b0;
    issue_chk("R4", 0, 0, 0, 0);
    cdb_valid_i = 1'b1; cdb_tag_i = 4'd5; cdb_data_i = 16'd55;
    step();
    cdb_valid_i = 1'b0;
    issue_chk("R3", 1, 2, 55, 3);
    step();
    issue_chk("R3", 0, 0, 0, 0);
  endtask

  task automatic t_same_cycle();
    cdb_valid_i = 1'b1; cdb_tag_i = 4'd7; cdb_data_i = 16'd77;
    put(4, 7, 0, 0, 7, 0, 0);
    cdb_valid_i = 1'b0;
    issue_chk("R5", 1, 4, 77, 77);
    step();
    issue_chk("R5", 0, 0, 0, 0);
  endtask

  task automatic t_age();
    alu_busy_i = 1'b1;
    put(1, 0, 11, 1, 0, 12, 1);   // slot 0, oldest
    put(2, 6, 0, 0, 0, 22, 1);    // slot 1, waits on tag 6
    alu_busy_i = 1'b0;
    issue_chk("R7", 1, 1, 11, 12);
    step();
    alu_busy_i = 1'b1;
    put(3, 0, 31, 1, 0, 32, 1);   // reuses slot 0, youngest
    cdb_valid_i = 1'b1; cdb_tag_i = 4'd6; cdb_data_i = 16'd66;
    step();
    cdb_valid_i = 1'b0;
    alu_busy_i = 1'b0;
    issue_chk("R7", 1, 2, 66, 22);
    step();
    issue_chk("R7", 1, 3, 31, 32);
    step();
    issue_chk("R7", 0, 0, 0, 0);
  endtask

  task automatic t_full();
    alu_busy_i = 1'b1;
    for (int k = 1; k <= 4; k++) put(k, 0, 40 + k, 1, 0, k, 1);
    #2;
    chk("R9", "disp_ready full", int'(disp_ready_o), 0);
    chk("R8", "iss_valid busy", int'(iss_valid_o), 0);
    put(5, 0, 50, 1, 0, 50, 1);   // refused
    #2;
    chk("R8", "iss_valid busy", int'(iss_valid_o), 0);
    alu_busy_i = 1'b0;
    issue_chk("R8", 1, 1, 41, 1);
    chk("R10", "disp_ready issue cycle", int'(disp_ready_o), 0);
    step();
    #2;
    chk("R10", "disp_ready after issue", int'(disp_ready_o), 1);
    issue_chk("R8", 1, 2, 42, 2);
    step();
    issue_chk("R8", 1, 3, 43, 3);
    step();
    issue_chk("R8", 1, 4, 44, 4);
    step();
    issue_chk("R9", 0, 0, 0, 0);
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_basic();
    t_ooo_wakeup();
    t_same_cycle();
    t_age();
    t_full();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule